// File: doc/BRIEF.md
# Phase-Multiplexed Processor Pin Interface

This block sits between a processor core with a 16-bit address bus and an 8-bit data bus and a narrow pin set: one 8-bit output port and one 8-bit bidirectional port. The bidirectional port is presented as separate input, output and output-enable signals. A bus cycle starts at a falling clock edge. It runs through the low clock phase, which is the address phase, and then the high clock phase, which is the data phase. It ends at the next falling edge. In the address phase the two ports together carry the full address. In the data phase the output port carries status and the bidirectional port carries data, which is written out or read in.

At each falling edge the interface loads the core's request (address, write data, read/write flag and opcode-fetch flag) into a request register, and the pins show that register for the whole bus cycle. The conditioned ready signal is the back-pressure rule. While it is low the request register is not loaded, so the pins repeat the same address and status every cycle, and the core is expected to hold its request too. A new request is accepted at the first falling edge at which ready is high again. Read data is taken from the pins at the falling edge that ends a read cycle and is given to the core during the following cycle.

Three control inputs share one 8-bit input port. They are an active-low level interrupt request, an active-low non-maskable interrupt that acts on its falling edge, and an active-high ready line. Each of them passes through a two-flop synchronizer. An NMI falling edge sets a sticky pending flag that only the core's acknowledge clears.

Top module: `pin_phase_if`

## Requirements
- R1: While the clock is low, `addr_pins` equals request address bits [7:0], `bidir_out` equals address bits [15:8] and `bidir_oe` is 1.
- R2: While the clock is high, `addr_pins[0]` is the request read/write flag (1 = read), `addr_pins[1]` is the opcode-fetch flag and `addr_pins[7:2]` are 0.
- R3: While the clock is high in a write cycle (read/write = 0), `bidir_oe` is 1 and `bidir_out` carries the request write data.
- R4: While the clock is high in a read cycle (read/write = 1), `bidir_oe` is 0, which releases the port.
- R5: `ctl_pins[0]` is an active-low interrupt request. `core_irq` is its inverse, delayed by two falling edges.
- R6: `ctl_pins[1]` is an active-low NMI. A 1-to-0 transition of its twice-synchronized value sets `core_nmi` at the next falling edge. `core_nmi` then stays set until a falling edge that samples `core_nmi_ack` high with no new edge arriving. A new edge wins over an acknowledge at the same edge. A steady low level never sets it again.
- R7: `ctl_pins[2]` is an active-high ready. `core_ready` is its value delayed by two falling edges.
- R8: `ctl_pins[7:3]` have no effect on any output.
- R9: At the falling edge that ends a read cycle, `bidir_in` is loaded into `core_rdata`. At the end of a write cycle `core_rdata` keeps its value.
- R10: At a falling edge with `core_ready` high, the core request is loaded and shown on the pins for the next bus cycle. With `core_ready` low the previous request is held and shown again.
- R11: During reset: `core_nmi`, `core_irq`, `core_ready` and `core_rdata` are 0, and the request register is a read of address 0 with the opcode-fetch flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; low = address phase, high = data phase |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_pins | input | 8 | Bit 0 IRQ (low active), bit 1 NMI (falling edge), bit 2 ready, bits 7:3 unused |
| addr_pins | output | 8 | Address low byte, or status in the high phase |
| bidir_in | input | 8 | Value sampled from the bidirectional port |
| bidir_out | output | 8 | Value driven onto the bidirectional port |
| bidir_oe | output | 1 | Output enable for the bidirectional port |
| core_addr | input | 16 | Core request address |
| core_wdata | input | 8 | Core write data |
| core_rw | input | 1 | Core read/write flag, 1 = read |
| core_sync | input | 1 | Core opcode-fetch flag |
| core_rdata | output | 8 | Captured read data |
| core_irq | output | 1 | Synchronized interrupt request, active high |
| core_nmi | output | 1 | NMI pending flag |
| core_nmi_ack | input | 1 | Core acknowledge that clears the NMI pending flag |
| core_ready | output | 1 | Synchronized ready; low means the core must hold its request |

## Verification
The hardest case to reach is the NMI edge detector meeting its acknowledge. A synchronized falling edge has to land on the same falling clock edge as an acknowledge, or while an earlier NMI is still pending. A long NMI low level must also be seen not to set the flag again once it has been acknowledged. The stimulus gets there with pulses of several lengths and gaps, swept against an acknowledge that is held high for long stretches and also toggled every cycle. A behavioural reference model of the synchronizer delays runs alongside. Ready is also dropped for several cycles while a write is outstanding, which tests the hold rule together with the write-data drive.

// File: rtl/pin_phase_pkg.sv
package pin_phase_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int CTL_W  = 8;

  // control input bit positions (decoded by the conditioner)
  localparam int IRQ_BIT = 0;
  localparam int NMI_BIT = 1;
  localparam int RDY_BIT = 2;
  localparam int NUM_CTL = 3;

  // status bit positions in the data phase
  localparam int ST_RW_BIT   = 0;
  localparam int ST_SYNC_BIT = 1;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
    logic              rw;
    logic              sync;
  } bus_req_t;

  localparam bus_req_t REQ_RESET = '{addr: '0, wdata: '0, rw: 1'b1, sync: 1'b0};
endpackage

// File: rtl/ctl_sync.sv
module ctl_sync #(
  parameter int              WIDTH     = 3,
  parameter int              STAGES    = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= RESET_VAL;
    else        stage_q[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= RESET_VAL;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/nmi_latch.sv
module nmi_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_n_sync,
  input  logic ack,
  output logic pending
);
  logic prev_q;
  logic fall;

  assign fall = prev_q & ~nmi_n_sync;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b1;
      pending <= 1'b0;
    end else begin
      prev_q <= nmi_n_sync;
      if (fall)     pending <= 1'b1;
      else if (ack) pending <= 1'b0;
    end
  end

  // R6: an edge sets the flag
  assert_nmi_edge_R6: assert property (@(negedge clk) disable iff (!rst_n)
    fall |=> pending);
  // R6: flag is sticky until acknowledged
  assert_nmi_sticky_R6: assert property (@(negedge clk) disable iff (!rst_n)
    (pending && !ack) |=> pending);
endmodule

// File: rtl/req_slot.sv
module req_slot
  import pin_phase_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  bus_req_t          req_in,
  input  logic [DATA_W-1:0] pin_data,
  output bus_req_t          req_q,
  output logic [DATA_W-1:0] rdata_q
);
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= REQ_RESET;
      rdata_q <= '0;
    end else begin
      if (req_q.rw) rdata_q <= pin_data;
      if (load_en)  req_q   <= req_in;
    end
  end

  assert_hold_R10: assert property (@(negedge clk) disable iff (!rst_n)
    !load_en |=> $stable(req_q));
  assert_rdata_keep_R9: assert property (@(negedge clk) disable iff (!rst_n)
    !req_q.rw |=> $stable(rdata_q));
endmodule

// File: rtl/phase_mux.sv
module phase_mux
  import pin_phase_pkg::*;
(
  input  logic              clk,
  input  bus_req_t          req,
  output logic [DATA_W-1:0] port_a,
  output logic [DATA_W-1:0] port_b,
  output logic              port_b_oe
);
  localparam int HI_LSB = ADDR_W - DATA_W;

  always_comb begin
    port_a    = '0;
    port_b    = '0;
    port_b_oe = 1'b0;
    if (!clk) begin
      port_a    = req.addr[DATA_W-1:0];
      port_b    = req.addr[ADDR_W-1:HI_LSB];
      port_b_oe = 1'b1;
    end else begin
      port_a[ST_RW_BIT]   = req.rw;
      port_a[ST_SYNC_BIT] = req.sync;
      port_b              = req.wdata;
      port_b_oe           = ~req.rw;
    end
  end
endmodule

// File: rtl/pin_phase_if.sv
module pin_phase_if
  import pin_phase_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTL_W-1:0]  ctl_pins,
  output logic [DATA_W-1:0] addr_pins,
  input  logic [DATA_W-1:0] bidir_in,
  output logic [DATA_W-1:0] bidir_out,
  output logic              bidir_oe,
  input  logic [ADDR_W-1:0] core_addr,
  input  logic [DATA_W-1:0] core_wdata,
  input  logic              core_rw,
  input  logic              core_sync,
  output logic [DATA_W-1:0] core_rdata,
  output logic              core_irq,
  output logic              core_nmi,
  input  logic              core_nmi_ack,
  output logic              core_ready
);
  localparam logic [NUM_CTL-1:0] CTL_IDLE = NUM_CTL'((1 << IRQ_BIT) | (1 << NMI_BIT));

  logic [NUM_CTL-1:0] ctl_raw, ctl_s;
  bus_req_t           req_in, req_q;

  assign ctl_raw[IRQ_BIT] = ctl_pins[IRQ_BIT];
  assign ctl_raw[NMI_BIT] = ctl_pins[NMI_BIT];
  assign ctl_raw[RDY_BIT] = ctl_pins[RDY_BIT];

  ctl_sync #(.WIDTH(NUM_CTL), .STAGES(SYNC_STAGES), .RESET_VAL(CTL_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(ctl_raw), .dout(ctl_s));

  nmi_latch u_nmi (
    .clk(clk), .rst_n(rst_n), .nmi_n_sync(ctl_s[NMI_BIT]),
    .ack(core_nmi_ack), .pending(core_nmi));

  assign core_irq   = ~ctl_s[IRQ_BIT];
  assign core_ready = ctl_s[RDY_BIT];

  assign req_in = '{addr: core_addr, wdata: core_wdata, rw: core_rw, sync: core_sync};

  req_slot u_slot (
    .clk(clk), .rst_n(rst_n), .load_en(core_ready), .req_in(req_in),
    .pin_data(bidir_in), .req_q(req_q), .rdata_q(core_rdata));

  phase_mux u_mux (
    .clk(clk), .req(req_q), .port_a(addr_pins), .port_b(bidir_out),
    .port_b_oe(bidir_oe));
endmodule

// File: tb/pin_phase_if_tb.sv
module pin_phase_if_tb;
  logic        clk = 1'b1;
  logic        rst_n = 1'b0;
  logic [7:0]  ctl_pins = 8'h03;
  logic [7:0]  addr_pins, bidir_in = 8'h00, bidir_out, core_rdata;
  logic        bidir_oe, core_irq, core_nmi, core_ready;
  logic [15:0] core_addr = 16'h0;
  logic [7:0]  core_wdata = 8'h0;
  logic        core_rw = 1'b1, core_sync = 1'b0, core_nmi_ack = 1'b0;

  int vectors = 0, miscompares = 0;
  bit done = 0;

  always #10 clk = ~clk;   // 50 MHz

  pin_phase_if u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_pins(ctl_pins), .addr_pins(addr_pins),
    .bidir_in(bidir_in), .bidir_out(bidir_out), .bidir_oe(bidir_oe),
    .core_addr(core_addr), .core_wdata(core_wdata), .core_rw(core_rw),
    .core_sync(core_sync), .core_rdata(core_rdata), .core_irq(core_irq),
    .core_nmi(core_nmi), .core_nmi_ack(core_nmi_ack), .core_ready(core_ready));

  // behavioural reference model
  int m_irq_d[$], m_nmi_d[$], m_rdy_d[$];
  int m_nmi_prev, m_pend;
  int m_addr, m_wdata, m_rw, m_sync, m_rdata;

  task automatic model_reset();
    m_irq_d = '{1, 1}; m_nmi_d = '{1, 1}; m_rdy_d = '{0, 0};
    m_nmi_prev = 1; m_pend = 0;
    m_addr = 0; m_wdata = 0; m_rw = 1; m_sync = 0; m_rdata = 0;
  endtask

  always @(negedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else begin
      int nmi_s, rdy_s;
      nmi_s = m_nmi_d[1];
      rdy_s = m_rdy_d[1];
      if (m_nmi_prev == 1 && nmi_s == 0) m_pend = 1;
      else if (core_nmi_ack) m_pend = 0;
      m_nmi_prev = nmi_s;
      if (m_rw == 1) m_rdata = bidir_in;
      if (rdy_s == 1) begin
        m_addr = core_addr; m_wdata = core_wdata; m_rw = core_rw; m_sync = core_sync;
      end
      void'(m_irq_d.pop_back()); m_irq_d.push_front(ctl_pins[0]);
      void'(m_nmi_d.pop_back()); m_nmi_d.push_front(ctl_pins[1]);
      void'(m_rdy_d.pop_back()); m_rdy_d.push_front(ctl_pins[2]);
    end
  end

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  task automatic check_common();
    chk("R5 irq", 16'(core_irq), 16'(m_irq_d[1] == 0));
    chk("R6 nmi", 16'(core_nmi), 16'(m_pend));
    chk("R7 ready", 16'(core_ready), 16'(m_rdy_d[1]));
    chk("R9 rdata", 16'(core_rdata), 16'(m_rdata));
  endtask

  task automatic check_low();  // R1, R10 (address phase shows held request)
    chk("R1 addr lo", 16'(addr_pins), 16'(m_addr & 8'hFF));
    chk("R1 addr hi", 16'(bidir_out), 16'((m_addr >> 8) & 8'hFF));
    chk("R1 oe", 16'(bidir_oe), 16'd1);
    check_common();
  endtask

  task automatic check_high();  // R2, R3, R4
    chk("R2 status", 16'(addr_pins), 16'((m_sync << 1) | m_rw));
    if (m_rw == 0) begin
      chk("R3 oe", 16'(bidir_oe), 16'd1);
      chk("R3 wdata", 16'(bidir_out), 16'(m_wdata));
    end else chk("R4 oe", 16'(bidir_oe), 16'd0);
    check_common();
  endtask

  // one bus cycle: drive after the rising edge, check both phases
  task automatic cycle(logic [7:0] ctl, logic [15:0] a, logic [7:0] wd, logic rw,
                       logic sy, logic [7:0] din, logic ack);
    @(posedge clk); #1;
    ctl_pins = ctl; core_addr = a; core_wdata = wd; core_rw = rw;
    core_sync = sy; bidir_in = din; core_nmi_ack = ack;
    #4 check_high();
    @(negedge clk); #5 check_low();
  endtask

  initial begin
    // R11: reset state
    repeat (2) @(negedge clk);
    #5;
    chk("R11 nmi", 16'(core_nmi), 16'd0);
    chk("R11 irq", 16'(core_irq), 16'd0);
    chk("R11 ready", 16'(core_ready), 16'd0);
    chk("R11 rdata", 16'(core_rdata), 16'd0);
    chk("R11 addr", {bidir_out, addr_pins}, 16'h0000);
    @(posedge clk); #5;
    chk("R11 status read", 16'(addr_pins), 16'h0001);
    chk("R11 oe released", 16'(bidir_oe), 16'd0);
    #1 rst_n = 1'b1;
    @(negedge clk); #5 check_low();

    // ready high, reads and writes with sync toggles
    for (int i = 0; i < 400; i++)
      cycle(8'h07, 16'($urandom), 8'($urandom), 1'($urandom), 1'($urandom),
            8'($urandom), 1'b0);

    // R10: stall with a write outstanding
    for (int i = 0; i < 40; i++)
      cycle({5'b0, (i % 10) >= 4 ? 1'b0 : 1'b1, 2'b11}, 16'(16'hA000 + i),
            8'(8'h50 + i), 1'b0, i[0], 8'($urandom), 1'b0);

    // R8: unused control bits toggled freely
    for (int i = 0; i < 200; i++)
      cycle({5'($urandom), 3'b111}, 16'($urandom), 8'($urandom), 1'($urandom),
            1'b0, 8'($urandom), 1'b0);

    // R5, R6: interrupt pulses of varying length against acknowledge patterns
    for (int len = 1; len <= 6; len++)
      for (int gap = 1; gap <= 5; gap++)
        for (int ackmode = 0; ackmode < 3; ackmode++)
          for (int t = 0; t < len + gap; t++)
            cycle({5'b10101, 1'b1, (t < len) ? 1'b0 : 1'b1, t[0]},
                  16'($urandom), 8'($urandom), 1'($urandom), 1'($urandom),
                  8'($urandom),
                  ackmode == 0 ? 1'b0 : ackmode == 1 ? 1'b1 : t[0]);

    // R6: long NMI low level after acknowledge does not re-set
    for (int t = 0; t < 20; t++)
      cycle({5'b0, 1'b1, 1'b0, 1'b1}, 16'h1234, 8'h00, 1'b1, 1'b0, 8'h5A,
            t >= 6);

    // full random mix
    for (int i = 0; i < 1500; i++)
      cycle(8'($urandom) | 8'(($urandom % 4 != 0) ? 4 : 0), 16'($urandom),
            8'($urandom), 1'($urandom), 1'($urandom), 8'($urandom),
            1'($urandom));

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #3_000_000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule